// File: doc/BRIEF.md
# Drift-Free Sine Sample Sequencer

This block plays back one cycle of a sine wave as a stream of duty words for a pulse-width modulator, paced entirely in hardware. A prescaler turns the system clock into a 1 MHz tick that drives a free-running 32-bit microsecond counter. A compare register holds the time of the next sample. When the counter reaches that time, the block reads the next entry of a built-in sine table and presents it on the duty output. It raises a one-cycle match strobe, sets a sticky match status flag, and moves the compare value forward by the sample interval.

The new target is the old target plus the interval, not the current time plus the interval. The spacing between samples is therefore exactly the interval and does not stretch by any service delay. The waveform frequency is the sample rate divided by the table length; for example, 30 µs per sample over 256 entries gives a period of about 7.68 ms, or roughly 130 Hz. If a newly computed target does not lie ahead of the counter, the block sets a sticky overrun flag, because the equality compare will not fire again until the counter wraps. Software starts playback with a single start pulse and clears either status flag by writing a one to its bit.

Top module: `drift_free_sine_seq`

## Requirements
- R1: After reset, duty_o is 512, match_o is low and both status flags are low; no strobe occurs and no flag is set before the first start pulse.
- R2: The table holds 256 entries, where entry i equals round(512 + 511*sin(2*pi*i/256)), so values run from 1 (entry 192) to 1023 (entry 64). The first strobe after start emits entry 0 and each later strobe emits the following entry.
- R3: The table position wraps from 255 back to 0, so the 257th strobe after a start emits entry 0 again.
- R4: At a start pulse the first target is the next counter value plus interval_i. With TICK_DIV system clocks per microsecond, the first strobe appears between (interval-1)*TICK_DIV+1 and interval*TICK_DIV clock edges after the edge that samples start_i.
- R5: Each later target is the previous target plus interval_i, so consecutive strobes are exactly interval*TICK_DIV clocks apart.
- R6: match_o is high for one cycle per match. duty_o takes its new value in that same cycle and holds it until the next match.
- R7: A match sets match_flag_o (status bit 0). A write with sts_wr_i high and sts_wdata_i[0]=1 clears it. A write with that bit at 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R8: If the signed 32-bit difference (new target minus counter) is zero or negative, overrun_o (status bit 1) is set. The flag stays set until a write with sts_wdata_i[1]=1, and no further strobe occurs until the counter wraps.
- R9: A start pulse at any time, including during playback, rewinds the table position to 0 and bases the target on the current counter, so any target that was pending is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts or restarts playback |
| interval_i | input | 32 | Sample interval in microseconds |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 2 | Write-one-to-clear mask: bit 0 is the match flag, bit 1 is overrun |
| duty_o | output | 10 | Current duty word from the sine table |
| match_o | output | 1 | One-cycle strobe on each compare match |
| match_flag_o | output | 1 | Sticky match status flag |
| overrun_o | output | 1 | Sticky missed-target flag |

## Verification
A wrong table position shows up on the very next strobe as a duty word that differs from the sine formula. A position that fails to wrap shows up one table length later, at the 257th sample. A compare value that is re-based on the current time, instead of on the old target, shows up at the second strobe as a gap that is not a whole multiple of the interval. A bad overrun judgement shows up either as a missing flag or as an unexpected strobe during the idle window that follows a zero interval. A start that does not rewind the position or drop the pending target shows up at the first strobe after the restart: it arrives too early, or it carries a value other than the table's first entry.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  localparam int TIME_W = 32;
  localparam int STS_W = 2;
  localparam int STS_MATCH = 0;
  localparam int STS_OVR = 1;
  localparam real PI_R = 3.14159265358979323846;

  typedef logic [TIME_W-1:0] tick_t;

  // Sample code for table slot idx of a depth-entry table with width-bit words
  function automatic int sine_code(int idx, int depth, int width);
    real mid;
    real amp;
    real ang;
    mid = real'(1 << (width - 1));
    amp = mid - 1.0;
    ang = 2.0 * PI_R * real'(idx) / real'(depth);
    return $rtoi(mid + amp * $sin(ang) + 0.5);
  endfunction

  // Next compare target: anchored on the previous target
  function automatic tick_t next_target(tick_t base, tick_t step);
    return base + step;
  endfunction

  // True when tgt still lies ahead of now on the wrapping time line
  function automatic logic is_ahead(tick_t tgt, tick_t now);
    return $signed(tgt - now) > 0;
  endfunction

endpackage

// File: rtl/dfs_timebase.sv
module dfs_timebase
  import dfs_pkg::*;
#(
  parameter int TICK_DIV = 125
) (
  input  logic  clk,
  input  logic  rst_n,
  output logic  tick_o,
  output tick_t now_nxt_o
);

  tick_t now_q;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] pre_q;
      assign tick_o = (pre_q == PRE_W'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate

  assign now_nxt_o = now_q + TIME_W'(tick_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else now_q <= now_nxt_o;
  end

endmodule

// File: rtl/dfs_sine_rom.sv
module dfs_sine_rom
  import dfs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WORD_W = 10,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [IW-1:0]     idx_i,
  output logic [WORD_W-1:0] data_o
);

  logic [WORD_W-1:0] rom [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      localparam logic [WORD_W-1:0] VAL = WORD_W'(sine_code(g, DEPTH, WORD_W));
      assign rom[g] = VAL;
    end
  endgenerate

  assign data_o = rom[idx_i];

endmodule

// File: rtl/dfs_scheduler.sv
module dfs_scheduler
  import dfs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DUTY_W = 10,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  tick_t             interval_i,
  input  logic              tick_i,
  input  tick_t             now_nxt_i,
  input  logic [DUTY_W-1:0] sample_i,
  output logic [IW-1:0]     idx_o,
  output logic              hit_o,
  output logic              ovr_evt_o,
  output logic              running_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              strobe_o
);

  localparam logic [DUTY_W-1:0] DUTY_RST = DUTY_W'(1 << (DUTY_W - 1));

  tick_t             cmp_q;
  logic              run_q;
  logic [IW-1:0]     idx_q;
  logic [DUTY_W-1:0] duty_q;
  logic              strobe_q;
  tick_t             start_tgt;
  tick_t             hit_tgt;

  assign start_tgt = next_target(now_nxt_i, interval_i);
  assign hit_tgt   = next_target(cmp_q, interval_i);

  // exact-equality compare on the counter value being loaded this edge
  assign hit_o = run_q && tick_i && !start_i && (now_nxt_i == cmp_q);

  always_comb begin
    if (start_i) ovr_evt_o = !is_ahead(start_tgt, now_nxt_i);
    else ovr_evt_o = hit_o && !is_ahead(hit_tgt, now_nxt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cmp_q    <= '0;
      idx_q    <= '0;
      duty_q   <= DUTY_RST;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= hit_o;
      if (start_i) begin
        run_q <= 1'b1;
        cmp_q <= start_tgt;
        idx_q <= '0;
      end else if (hit_o) begin
        cmp_q  <= hit_tgt;
        idx_q  <= idx_q + 1'b1;
        duty_q <= sample_i;
      end
    end
  end

  assign idx_o     = idx_q;
  assign running_o = run_q;
  assign duty_o    = duty_q;
  assign strobe_o  = strobe_q;

endmodule

// File: rtl/dfs_status.sv
module dfs_status
  import dfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_i,
  input  logic             wr_i,
  input  logic [STS_W-1:0] wdata_i,
  output logic [STS_W-1:0] flags_o
);

  logic [STS_W-1:0] flag_q;

  generate
    for (genvar b = 0; b < STS_W; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[b] <= 1'b0;
        else if (set_i[b]) flag_q[b] <= 1'b1;
        else if (wr_i && wdata_i[b]) flag_q[b] <= 1'b0;
      end
    end
  endgenerate

  assign flags_o = flag_q;

endmodule

// File: rtl/drift_free_sine_seq.sv
module drift_free_sine_seq
  import dfs_pkg::*;
#(
  parameter int TICK_DIV = 125,
  parameter int TABLE_DEPTH = 256,
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       interval_i,
  input  logic              sts_wr_i,
  input  logic [1:0]        sts_wdata_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              match_o,
  output logic              match_flag_o,
  output logic              overrun_o
);

  localparam int IDX_W = $clog2(TABLE_DEPTH);

  logic              tick_w;
  tick_t             now_nxt_w;
  logic [IDX_W-1:0]  idx_w;
  logic [DUTY_W-1:0] sample_w;
  logic              hit_w;
  logic              ovr_evt_w;
  logic              run_w;
  logic [STS_W-1:0]  sts_set_w;
  logic [STS_W-1:0]  sts_w;

  dfs_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_o    (tick_w),
    .now_nxt_o (now_nxt_w)
  );

  dfs_sine_rom #(.DEPTH(TABLE_DEPTH), .WORD_W(DUTY_W)) u_rom (
    .idx_i  (idx_w),
    .data_o (sample_w)
  );

  dfs_scheduler #(.DEPTH(TABLE_DEPTH), .DUTY_W(DUTY_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .interval_i (interval_i),
    .tick_i     (tick_w),
    .now_nxt_i  (now_nxt_w),
    .sample_i   (sample_w),
    .idx_o      (idx_w),
    .hit_o      (hit_w),
    .ovr_evt_o  (ovr_evt_w),
    .running_o  (run_w),
    .duty_o     (duty_o),
    .strobe_o   (match_o)
  );

  always_comb begin
    sts_set_w            = '0;
    sts_set_w[STS_MATCH] = hit_w;
    sts_set_w[STS_OVR]   = ovr_evt_w;
  end

  dfs_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (sts_set_w),
    .wr_i    (sts_wr_i),
    .wdata_i (sts_wdata_i),
    .flags_o (sts_w)
  );

  assign match_flag_o = sts_w[STS_MATCH];
  assign overrun_o    = sts_w[STS_OVR];

endmodule

// File: rtl/dfs_seq_chk.sv
module dfs_seq_chk #(
  parameter int IDX_W = 8,
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              sts_wr_i,
  input logic [1:0]        sts_wdata_i,
  input logic [DUTY_W-1:0] duty_o,
  input logic              match_o,
  input logic              match_flag_o,
  input logic              overrun_o,
  input logic              tick_w,
  input logic              hit_w,
  input logic              run_w,
  input logic [IDX_W-1:0]  idx_w
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |-> (!match_o && !match_flag_o)); // R1

  AST_HIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |-> tick_w); // R5

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |-> $stable(duty_o)); // R6

  AST_FLAG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> match_flag_o); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !(sts_wr_i && sts_wdata_i[1])) |=> overrun_o); // R8

  AST_START_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (idx_w == '0)); // R9

endmodule

bind drift_free_sine_seq dfs_seq_chk #(.IDX_W(IDX_W), .DUTY_W(DUTY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .sts_wr_i     (sts_wr_i),
  .sts_wdata_i  (sts_wdata_i),
  .duty_o       (duty_o),
  .match_o      (match_o),
  .match_flag_o (match_flag_o),
  .overrun_o    (overrun_o),
  .tick_w       (tick_w),
  .hit_w        (hit_w),
  .run_w        (run_w),
  .idx_w        (idx_w)
);

// File: tb/drift_free_sine_seq_tb_top.sv
`timescale 1ns/1ps
module drift_free_sine_seq_tb_top;

  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] interval_i = 32'd0;
  logic        sts_wr_i = 1'b0;
  logic [1:0]  sts_wdata_i = 2'b00;
  logic [9:0]  duty_o;
  logic        match_o;
  logic        match_flag_o;
  logic        overrun_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int exp_q[$];
  int pos_q[$];
  int exp_gap = 0;
  bit first_pending = 1'b0;
  int start_cyc = 0;
  int cur_iv = 0;
  int last_cyc = 0;
  int last_duty = 512;
  int hold_viol = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  drift_free_sine_seq #(.TICK_DIV(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .interval_i(interval_i),
    .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i), .duty_o(duty_o),
    .match_o(match_o), .match_flag_o(match_flag_o), .overrun_o(overrun_o)
  );

  function automatic int ref_sine(int p);
    real ph;
    real v;
    ph = 2.0 * 3.141592653589793 * real'(p % 256) / 256.0;
    v = 512.0 + 511.0 * $sin(ph);
    return int'($floor(v + 0.5));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver side: queue the samples the design must emit
  task automatic push_run(int first, int n);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(ref_sine(first + k));
      pos_q.push_back(first + k);
    end
  endtask

  task automatic do_start(int iv);
    @(negedge clk);
    start_i = 1'b1;
    interval_i = 32'(iv);
    cur_iv = iv;
    exp_gap = iv * D;
    start_cyc = cyc + 1;
    first_pending = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic sts_write(logic [1:0] m);
    @(negedge clk);
    sts_wr_i = 1'b1;
    sts_wdata_i = m;
    @(negedge clk);
    sts_wr_i = 1'b0;
    sts_wdata_i = 2'b00;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor side: pop and compare as strobes appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (match_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 R8", "unexpected match strobe", 1, 0);
        end else begin
          int e;
          int p;
          e = exp_q.pop_front();
          p = pos_q.pop_front();
          chk(int'(duty_o) == e, (p >= 256) ? "R3" : "R2", "duty word", duty_o, e);
          if (first_pending) begin
            int dly;
            dly = cyc - start_cyc;
            chk(dly >= (cur_iv - 1) * D + 1 && dly <= cur_iv * D, "R4 R9",
                "first strobe delay", dly, cur_iv * D);
            first_pending = 1'b0;
          end else begin
            chk(cyc - last_cyc == exp_gap, "R5", "strobe spacing", cyc - last_cyc, exp_gap);
          end
          last_cyc = cyc;
        end
      end else if (int'(duty_o) != last_duty) begin
        hold_viol++;
      end
      last_duty = int'(duty_o);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(duty_o == 10'd512, "R1", "reset duty", duty_o, 512);
    chk(match_o == 1'b0, "R1", "reset strobe", match_o, 0);
    chk(match_flag_o == 1'b0 && overrun_o == 1'b0, "R1", "reset flags",
        {match_flag_o, overrun_o}, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(match_flag_o == 1'b0, "R1", "no flag before start", match_flag_o, 0);

    // R2 R3 R4 R5: play more than one full table at 2 us per sample
    push_run(0, 300);
    do_start(2);
    drain();
    chk(match_flag_o == 1'b1, "R7", "match flag after playback", match_flag_o, 1);

    // R8: zero interval makes the next target miss
    interval_i = 32'd0;
    push_run(300, 1);
    drain();
    @(negedge clk);
    chk(overrun_o == 1'b1, "R8", "overrun after zero interval", overrun_o, 1);
    repeat (300) @(negedge clk);
    chk(overrun_o == 1'b1, "R8", "overrun sticky", overrun_o, 1);

    // R7: write-one-to-clear behaviour while playback is stalled
    sts_write(2'b00);
    chk(match_flag_o == 1'b1, "R7", "zero write keeps match flag", match_flag_o, 1);
    chk(overrun_o == 1'b1, "R8", "zero write keeps overrun", overrun_o, 1);
    sts_write(2'b10);
    chk(overrun_o == 1'b0, "R8", "overrun cleared by bit1", overrun_o, 0);
    chk(match_flag_o == 1'b1, "R7", "bit1 write keeps match flag", match_flag_o, 1);
    sts_write(2'b01);
    chk(match_flag_o == 1'b0, "R7", "match flag cleared by bit0", match_flag_o, 0);

    // R9: restart from a stall at 5 us per sample
    push_run(0, 12);
    do_start(5);
    drain();
    chk(overrun_o == 1'b0, "R8", "no overrun with positive interval", overrun_o, 0);

    // R9: restart during playback, pending target must be dropped
    push_run(0, 10);
    do_start(3);
    drain();
    chk(exp_q.size() == 0, "R9", "restart sequence consumed", exp_q.size(), 0);
    chk(hold_viol == 0, "R6", "duty changes without strobe", hold_viol, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule